// File: doc/BRIEF.md
# Serial NAND Feature Register Target

This block is the command front end of a serial NAND flash model, seen from the device side of a single-lane SPI link. It watches chip-select, the serial clock and the host data line, assembles command bytes, and answers four commands: feature read, feature write, identification read and device reset. It holds a small bank of feature registers: the block-protection register, the configuration register, the status register and the die-select register. It also produces the busy indication that follows a reset.

The SPI pins are oversampled in the system clock domain through a synchronizer chain. The serial clock must therefore stay at least four system clocks in each phase. Bytes are taken in on serial-clock rising edges. Reply bits change after falling edges, so a mode-0 host samples them on the next rising edge. Two test inputs let a bench or a higher-level model raise the erase-fail and program-fail flags without a memory array behind the block.

Top module: `snand_feat_target`

## Requirements
- R1: SPI mode 0 with the most significant bit first. The host line is captured on serial-clock rising edges. `spi_miso` reads 0 whenever the target has no reply byte to send: while chip-select is high, and during the opcode and address bytes.
- R2: Feature read is opcode 0x0F, then one address byte. The target then returns the addressed register. Every further byte in the same transaction returns the register's current value again. Addresses: 0xA0 protection, 0xB0 configuration, 0xC0 status, 0xD0 die select.
- R3: Feature write is opcode 0x1F, then an address byte and a data byte. Only the defined bits can be written: protection mask 0x7C, configuration mask 0x31 (bit 0 quad enable, bit 4 ECC enable, bit 5 lock-tight), die-select mask 0x40 (bit 6). Bits outside the mask read 0.
- R4: After system reset, protection reads 0x7C (all blocks locked), configuration reads 0x10, and status and die select read 0x00. Writing 0x00 to protection unlocks every block, and protection then reads 0x00.
- R5: The status register is read-only. Bit 0 is busy, bit 2 is erase fail, bit 3 is program fail and bit 7 is cache busy, which always reads 0. A feature write to 0xC0 changes nothing.
- R6: A read from any other address returns 0x00. A write to any other address changes no register.
- R7: Opcode 0x9F returns the manufacturer code first and then the device code. Later bytes return 0x00.
- R8: Opcode 0xFF sets status bit 0 for exactly BUSY_CYCLES system clocks after the opcode byte completes, and then clears it. It also clears both fail flags.
- R9: A feature write that completes while status bit 0 is set is ignored.
- R10: Raising chip-select ends the command in progress. A feature write whose data byte is not complete has no effect, and the next transaction starts again at bit 0 of a fresh opcode.
- R11: A high on `force_erase_fail` sets status bit 2, and a high on `force_prog_fail` sets status bit 3. Each flag stays set until a reset command.
- R12: An unrecognised opcode makes the target ignore the rest of the transaction. It keeps `spi_miso` at 0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | SPI chip-select, active low |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_mosi | input | 1 | Host-to-target serial data |
| force_erase_fail | input | 1 | Test input that sets the erase-fail flag |
| force_prog_fail | input | 1 | Test input that sets the program-fail flag |
| spi_miso | output | 1 | Target-to-host serial data, 0 when idle |

## Verification
Random feature reads and writes, with the address drawn from the four defined registers or from undefined values and the data drawn from full bytes, separate correct write masks and address decode from near misses such as a missing mask or a decode that matches on the high nibble only. Reads of two bytes in a row separate a repeating reply from one that runs out. Directed sequences cover the rest. A reset followed at once by a protection write and a status read tells a correct busy window from one that is missing or too short. A write cut off mid-byte, an unknown opcode and the forced fail flags each check a case that random traffic does not reach.

// File: rtl/snand_pkg.sv
package snand_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_FEAT_RD = 8'h0F;
    localparam logic [BYTE_W-1:0] OPC_FEAT_WR = 8'h1F;
    localparam logic [BYTE_W-1:0] OPC_IDENT   = 8'h9F;
    localparam logic [BYTE_W-1:0] OPC_DEV_RST = 8'hFF;

    localparam logic [BYTE_W-1:0] FA_PROTECT  = 8'hA0;
    localparam logic [BYTE_W-1:0] FA_CONFIG   = 8'hB0;
    localparam logic [BYTE_W-1:0] FA_STATUS   = 8'hC0;
    localparam logic [BYTE_W-1:0] FA_DIESEL   = 8'hD0;

    typedef enum logic [2:0] {
        FR_NONE,
        FR_PROTECT,
        FR_CONFIG,
        FR_STATUS,
        FR_DIESEL
    } freg_e;

    typedef enum logic [2:0] {
        CS_OPCODE,
        CS_RD_ADDR,
        CS_WR_ADDR,
        CS_WR_DATA,
        CS_RD_OUT,
        CS_ID_OUT,
        CS_DRAIN
    } cmd_state_e;

    typedef struct packed {
        logic              vld;
        freg_e             sel;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    // number of host-writable registers in the bank
    localparam int NUM_RW = 3;

    function automatic freg_e addr_to_reg(input logic [BYTE_W-1:0] a);
        freg_e r;
        case (a)
            FA_PROTECT: r = FR_PROTECT;
            FA_CONFIG:  r = FR_CONFIG;
            FA_STATUS:  r = FR_STATUS;
            FA_DIESEL:  r = FR_DIESEL;
            default:    r = FR_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] wr_mask(input freg_e r);
        logic [BYTE_W-1:0] m;
        case (r)
            FR_PROTECT: m = 8'h7C;
            FR_CONFIG:  m = 8'h31;
            FR_DIESEL:  m = 8'h40;
            default:    m = 8'h00;
        endcase
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] init_val(input freg_e r);
        logic [BYTE_W-1:0] v;
        case (r)
            FR_PROTECT: v = 8'h7C;
            FR_CONFIG:  v = 8'h10;
            default:    v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic freg_e rw_slot(input int i);
        freg_e r;
        case (i)
            0:       r = FR_PROTECT;
            1:       r = FR_CONFIG;
            default: r = FR_DIESEL;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/snand_spi_front.sv
module snand_spi_front
    import snand_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_csn,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              cs_act,
    output logic              rx_vld,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_bit
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [SYNC_STAGES-1:0] csn_p, sck_p, mosi_p;
    logic                   sck_q;
    logic                   csn_s, sck_s, mosi_s;
    logic                   sck_rise, sck_fall;
    logic [CNT_W-1:0]       bit_cnt;
    logic [BYTE_W-1:0]      rx_sh, tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_p  <= '1;
            sck_p  <= '0;
            mosi_p <= '0;
        end else begin
            csn_p  <= {csn_p[SYNC_STAGES-2:0], spi_csn};
            sck_p  <= {sck_p[SYNC_STAGES-2:0], spi_sck};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
        end
    end

    assign csn_s    = csn_p[SYNC_STAGES-1];
    assign sck_s    = sck_p[SYNC_STAGES-1];
    assign mosi_s   = mosi_p[SYNC_STAGES-1];
    assign cs_act   = ~csn_s;
    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            rx_vld  <= 1'b0;
            rx_byte <= '0;
            tx_sh   <= '0;
        end else begin
            sck_q  <= sck_s;
            rx_vld <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                    rx_vld  <= 1'b1;
                    rx_byte <= {rx_sh[BYTE_W-2:0], mosi_s};
                end
            end
            // the falling edge that closes a byte keeps the freshly loaded MSB
            if (tx_load) begin
                tx_sh <= tx_byte;
            end else if (cs_act && sck_fall && bit_cnt != '0) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign tx_bit = tx_sh[BYTE_W-1];

endmodule

// File: rtl/snand_cmd_ctrl.sv
module snand_cmd_ctrl
    import snand_pkg::*;
#(
    parameter logic [7:0] MFR_CODE = 8'hA5,
    parameter logic [7:0] DEV_CODE = 8'h3E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              rx_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] rd_data,
    output freg_e             rd_sel,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              reply_oe,
    output reg_wr_t           wr_req,
    output logic              rst_cmd
);
    cmd_state_e st_q, st_n;
    freg_e      sel_q, sel_n;
    logic [1:0] id_idx_q, id_idx_n;
    logic       take;

    assign take = rx_vld & cs_act;

    always_comb begin
        st_n     = st_q;
        sel_n    = sel_q;
        id_idx_n = id_idx_q;
        rd_sel   = sel_q;
        tx_load  = 1'b0;
        tx_byte  = '0;
        wr_req   = '0;
        rst_cmd  = 1'b0;
        if (take) begin
            case (st_q)
                CS_OPCODE: begin
                    case (rx_byte)
                        OPC_FEAT_RD: st_n = CS_RD_ADDR;
                        OPC_FEAT_WR: st_n = CS_WR_ADDR;
                        OPC_IDENT: begin
                            st_n     = CS_ID_OUT;
                            tx_load  = 1'b1;
                            tx_byte  = MFR_CODE;
                            id_idx_n = 2'd0;
                        end
                        OPC_DEV_RST: begin
                            rst_cmd = 1'b1;
                            st_n    = CS_DRAIN;
                        end
                        default: st_n = CS_DRAIN;
                    endcase
                end
                CS_RD_ADDR: begin
                    rd_sel  = addr_to_reg(rx_byte);
                    sel_n   = rd_sel;
                    tx_load = 1'b1;
                    tx_byte = rd_data;
                    st_n    = CS_RD_OUT;
                end
                CS_RD_OUT: begin
                    tx_load = 1'b1;
                    tx_byte = rd_data;
                end
                CS_WR_ADDR: begin
                    sel_n = addr_to_reg(rx_byte);
                    st_n  = CS_WR_DATA;
                end
                CS_WR_DATA: begin
                    wr_req.vld  = 1'b1;
                    wr_req.sel  = sel_q;
                    wr_req.data = rx_byte;
                    st_n        = CS_DRAIN;
                end
                CS_ID_OUT: begin
                    tx_load = 1'b1;
                    tx_byte = (id_idx_q == 2'd0) ? DEV_CODE : '0;
                    if (id_idx_q != 2'd3) id_idx_n = id_idx_q + 2'd1;
                end
                default: st_n = CS_DRAIN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            st_q     <= CS_OPCODE;
            sel_q    <= FR_NONE;
            id_idx_q <= '0;
        end else begin
            st_q     <= st_n;
            sel_q    <= sel_n;
            id_idx_q <= id_idx_n;
        end
    end

    assign reply_oe = cs_act & ((st_q == CS_RD_OUT) | (st_q == CS_ID_OUT));

endmodule

// File: rtl/snand_feat_bank.sv
module snand_feat_bank
    import snand_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr_req,
    input  freg_e             rd_sel,
    input  logic              rst_cmd,
    input  logic              force_efail,
    input  logic              force_pfail,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] stat_q,
    output logic [BYTE_W-1:0] lock_q
);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    logic [BUSY_W-1:0]            busy_cnt;
    logic                         busy;
    logic                         efail_q, pfail_q;
    logic [NUM_RW-1:0][BYTE_W-1:0] rw_vec;

    assign busy = (busy_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
            efail_q  <= 1'b0;
            pfail_q  <= 1'b0;
        end else begin
            if (rst_cmd) begin
                busy_cnt <= BUSY_W'(BUSY_CYCLES);
                efail_q  <= 1'b0;
                pfail_q  <= 1'b0;
            end else if (busy) begin
                busy_cnt <= busy_cnt - 1'b1;
            end
            if (force_efail) efail_q <= 1'b1;
            if (force_pfail) pfail_q <= 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
            localparam freg_e SLOT = rw_slot(g);
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= init_val(SLOT);
                end else if (wr_req.vld && !busy && wr_req.sel == SLOT) begin
                    q <= wr_req.data & wr_mask(SLOT);
                end
            end
            assign rw_vec[g] = q;
        end
    endgenerate

    // bit 7 cache busy: no cache behind this block, reads 0
    assign stat_q = {1'b0, 3'b000, pfail_q, efail_q, 1'b0, busy};
    assign lock_q = rw_vec[0];

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rw_slot(i) == rd_sel) rd_data = rw_vec[i];
        end
        if (rd_sel == FR_STATUS) rd_data = stat_q;
    end

endmodule

// File: rtl/snand_feat_target.sv
module snand_feat_target
    import snand_pkg::*;
#(
    parameter int         BUSY_CYCLES = 64,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] MFR_CODE    = 8'hA5,
    parameter logic [7:0] DEV_CODE    = 8'h3E
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_csn,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic force_erase_fail,
    input  logic force_prog_fail,
    output logic spi_miso
);
    logic              cs_act, rx_vld, tx_load, tx_bit, reply_oe, rst_cmd;
    logic [BYTE_W-1:0] rx_byte, tx_byte, rd_data, stat_q, lock_q;
    freg_e             rd_sel;
    reg_wr_t           wr_req;

    snand_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst      (rst),
        .spi_csn  (spi_csn),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .cs_act   (cs_act),
        .rx_vld   (rx_vld),
        .rx_byte  (rx_byte),
        .tx_bit   (tx_bit)
    );

    snand_cmd_ctrl #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .rx_vld   (rx_vld),
        .rx_byte  (rx_byte),
        .rd_data  (rd_data),
        .rd_sel   (rd_sel),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .reply_oe (reply_oe),
        .wr_req   (wr_req),
        .rst_cmd  (rst_cmd)
    );

    snand_feat_bank #(.BUSY_CYCLES(BUSY_CYCLES)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_req      (wr_req),
        .rd_sel      (rd_sel),
        .rst_cmd     (rst_cmd),
        .force_efail (force_erase_fail),
        .force_pfail (force_prog_fail),
        .rd_data     (rd_data),
        .stat_q      (stat_q),
        .lock_q      (lock_q)
    );

    assign spi_miso = reply_oe & tx_bit;

endmodule

// File: rtl/snand_feat_target_chk.sv
module snand_feat_target_chk #(
    parameter int BUSY_CYCLES = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_act,
    input logic       spi_miso,
    input logic       rst_cmd,
    input logic       force_erase_fail,
    input logic       force_prog_fail,
    input logic [7:0] stat_q,
    input logic [7:0] lock_q
);
    localparam int WIN_W = $clog2(BUSY_CYCLES + 1);

    logic [WIN_W-1:0] win;

    always_ff @(posedge clk) begin
        if (rst)                win <= '0;
        else if (rst_cmd)       win <= WIN_W'(BUSY_CYCLES);
        else if (win != '0)     win <= win - 1'b1;
    end

    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cs_act |-> !spi_miso) else $error("miso driven while deselected"); // R1

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        (win != '0) |-> stat_q[0]) else $error("busy dropped early"); // R8

    AST_BUSY_DONE: assert property (@(posedge clk) disable iff (rst)
        (win == '0) |-> !stat_q[0]) else $error("busy held too long"); // R8

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        stat_q[0] |=> $stable(lock_q)) else $error("write accepted while busy"); // R9

    AST_EFAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        force_erase_fail |=> stat_q[2]) else $error("erase fail not set"); // R11

    AST_PFAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        force_prog_fail |=> stat_q[3]) else $error("program fail not set"); // R11

endmodule

bind snand_feat_target snand_feat_target_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .cs_act           (cs_act),
    .spi_miso         (spi_miso),
    .rst_cmd          (rst_cmd),
    .force_erase_fail (force_erase_fail),
    .force_prog_fail  (force_prog_fail),
    .stat_q           (stat_q),
    .lock_q           (lock_q)
);

// File: tb/snand_feat_target_bench.sv
module snand_feat_target_bench;

    localparam int         BUSY = 1000;
    localparam int         HALF = 5;
    localparam logic [7:0] MFR  = 8'hA5;
    localparam logic [7:0] DEV  = 8'h3E;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic force_erase_fail = 1'b0, force_prog_fail = 1'b0;
    logic spi_miso;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] txb [8];
    logic [7:0] rxb [8];

    // reference model
    logic [7:0] m_lock = 8'h7C, m_cfg = 8'h10, m_die = 8'h00;
    logic       m_ef = 1'b0, m_pf = 1'b0;

    always #10 clk = ~clk;

    snand_feat_target #(
        .BUSY_CYCLES(BUSY), .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) u_snand_feat_target (
        .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .force_erase_fail(force_erase_fail),
        .force_prog_fail(force_prog_fail), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'hA0:   return m_lock;
            8'hB0:   return m_cfg;
            8'hC0:   return {4'b0, m_pf, m_ef, 2'b0};
            8'hD0:   return m_die;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'hA0: m_lock = d & 8'h7C;
            8'hB0: m_cfg  = d & 8'h31;
            8'hD0: m_die  = d & 8'h40;
            default: ;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] d, input int nb, output logic [7:0] r);
        r = '0;
        for (int i = 7; i >= 8 - nb; i--) begin
            spi_mosi = d[i];
            repeat (HALF) @(negedge clk);
            r[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic spi_txn(input int nbytes, input int extra_bits);
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbytes; i++) spi_byte(txb[i], 8, rxb[i]);
        if (extra_bits > 0) spi_byte(txb[nbytes], extra_bits, rxb[nbytes]);
        repeat (3) @(negedge clk);
        spi_csn = 1'b1;
        repeat (8) @(negedge clk);
        check("R1 idle miso", {7'b0, spi_miso}, 8'h00);
    endtask

    task automatic get_feat(input logic [7:0] a, output logic [7:0] d0, output logic [7:0] d1);
        txb[0] = 8'h0F; txb[1] = a; txb[2] = 8'h00; txb[3] = 8'h00;
        spi_txn(4, 0);
        check("R1 miso quiet in opcode", rxb[0], 8'h00);
        check("R1 miso quiet in address", rxb[1], 8'h00);
        d0 = rxb[2];
        d1 = rxb[3];
    endtask

    task automatic set_feat(input logic [7:0] a, input logic [7:0] d);
        txb[0] = 8'h1F; txb[1] = a; txb[2] = d;
        spi_txn(3, 0);
    endtask

    task automatic read_expect(input string req, input logic [7:0] a, input logic [7:0] e);
        logic [7:0] d0, d1;
        get_feat(a, d0, d1);
        check(req, d0, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d0, d1, a, d;
        logic [7:0] atab [4];
        atab[0] = 8'hA0; atab[1] = 8'hB0; atab[2] = 8'hC0; atab[3] = 8'hD0;
        void'($urandom(32'h5EED1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        // R4 power-up values
        read_expect("R4 protect reset", 8'hA0, 8'h7C);
        read_expect("R4 config reset", 8'hB0, 8'h10);
        read_expect("R4 status reset", 8'hC0, 8'h00);
        read_expect("R4 die reset", 8'hD0, 8'h00);

        // R3 write masks
        set_feat(8'hB0, 8'hFF); model_wr(8'hB0, 8'hFF);
        read_expect("R3 config mask", 8'hB0, 8'h31);
        set_feat(8'hD0, 8'hFF); model_wr(8'hD0, 8'hFF);
        read_expect("R3 die mask", 8'hD0, 8'h40);
        set_feat(8'hA0, 8'hFF); model_wr(8'hA0, 8'hFF);
        read_expect("R3 protect mask", 8'hA0, 8'h7C);
        set_feat(8'hA0, 8'h00); model_wr(8'hA0, 8'h00);
        read_expect("R4 unlock all", 8'hA0, 8'h00);

        // R2 repeated reply
        get_feat(8'hB0, d0, d1);
        check("R2 first byte", d0, 8'h31);
        check("R2 repeated byte", d1, 8'h31);

        // R5 status read-only
        set_feat(8'hC0, 8'hFF);
        read_expect("R5 status write ignored", 8'hC0, 8'h00);

        // R6 unknown address
        set_feat(8'h33, 8'hFF);
        read_expect("R6 unknown read", 8'h33, 8'h00);
        for (int i = 0; i < 4; i++) read_expect("R6 no side effect", atab[i], exp_rd(atab[i]));

        // R10 aborted write
        txb[0] = 8'h1F; txb[1] = 8'hA0; txb[2] = 8'h7C;
        spi_txn(2, 4);
        read_expect("R10 aborted write", 8'hA0, 8'h00);

        // R12 unknown opcode
        txb[0] = 8'h55; txb[1] = 8'hA0; txb[2] = 8'hFF;
        spi_txn(3, 0);
        check("R12 quiet byte 1", rxb[1], 8'h00);
        check("R12 quiet byte 2", rxb[2], 8'h00);
        read_expect("R12 no register change", 8'hA0, 8'h00);

        // R7 identification
        txb[0] = 8'h9F; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
        spi_txn(4, 0);
        check("R7 opcode phase quiet", rxb[0], 8'h00);
        check("R7 manufacturer", rxb[1], MFR);
        check("R7 device", rxb[2], DEV);
        check("R7 trailing", rxb[3], 8'h00);

        // R11 forced fail flags
        @(negedge clk) force_erase_fail = 1'b1;
        @(negedge clk) force_erase_fail = 1'b0;
        m_ef = 1'b1;
        read_expect("R11 erase fail", 8'hC0, 8'h04);
        @(negedge clk) force_prog_fail = 1'b1;
        @(negedge clk) force_prog_fail = 1'b0;
        m_pf = 1'b1;
        read_expect("R11 program fail sticky", 8'hC0, 8'h0C);

        // R8/R9 reset command and busy window
        txb[0] = 8'hFF;
        spi_txn(1, 0);
        m_ef = 1'b0; m_pf = 1'b0;
        set_feat(8'hA0, 8'h7C);
        read_expect("R8 busy after reset", 8'hC0, 8'h01);
        read_expect("R9 write during busy", 8'hA0, 8'h00);
        repeat (BUSY + 100) @(negedge clk);
        read_expect("R8 ready after window", 8'hC0, 8'h00);
        set_feat(8'hA0, 8'h7C); model_wr(8'hA0, 8'h7C);
        read_expect("R9 write after busy", 8'hA0, 8'h7C);

        // random traffic
        for (int it = 0; it < 60; it++) begin
            int op, k;
            op = int'($urandom % 3);
            k  = int'($urandom % 5);
            if (k < 4) a = atab[k];
            else begin
                a = 8'($urandom);
                if (a[3:0] == 4'h0 && a[7:4] >= 4'hA && a[7:4] <= 4'hD) a = a ^ 8'h01;
            end
            d = 8'($urandom);
            case (op)
                0: begin
                    get_feat(a, d0, d1);
                    check("R2 random read", d0, exp_rd(a));
                    check("R2 random repeat", d1, exp_rd(a));
                end
                1: begin
                    set_feat(a, d);
                    model_wr(a, d);
                end
                default: begin
                    txb[0] = 8'h9F; txb[1] = 8'h00; txb[2] = 8'h00;
                    spi_txn(3, 0);
                    check("R7 random id mfr", rxb[1], MFR);
                    check("R7 random id dev", rxb[2], DEV);
                end
            endcase
        end
        for (int i = 0; i < 4; i++) read_expect("R3 final state", atab[i], exp_rd(atab[i]));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule